// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a four-bank SDRAM on every rising clock edge. Those pins are chip select, row strobe, column strobe and write enable, all active low. It turns each pin pattern into a command code. It follows each bank as idle or open and records the row held open in each bank. A set of cycle counters checks every command against a fixed list of minimum spacings, counted in clock cycles.

The block can sit beside a memory controller as a protocol checker. It can also serve as the front end of a behavioural memory model. Every result appears on registered outputs one cycle after the command is sampled:

- a command code;
- a violation flag and a reason code;
- the open mask and open rows of all banks.

A command that breaks a rule is reported and has no effect on bank state. A precharge aimed at a bank with no open row is accepted silently and does nothing. Data transfer, mode register contents and electrical timing are not modelled.

Top module: `sdcmd_tracker`

## Requirements
- R1: Pins {cs_n,ras_n,cas_n,we_n} decode to `cmd_code` as follows: cs_n=1 gives 0 (deselect), 0111 gives 1 (no-op), 0110 gives 2 (burst stop), 0101 gives 3 (read), 0100 gives 4 (write), 0011 gives 5 (activate), 0010 gives 6 (precharge), 0001 gives 7 (auto refresh) and 0000 gives 8 (mode load). Deselect and no-op are never flagged.
- R2: The command sampled at a rising edge sets `cmd_code`, `viol` and `viol_code` right after that edge, and they hold for exactly one cycle. `viol` is 1 exactly when `viol_code` is nonzero, so a legal command reports code 0.
- R3: After synchronous reset, all banks are idle, every open row reads 0, `cmd_code` is 0, `viol` is 0, and every spacing counter counts as expired.
- R4: An activate to an idle bank selected by `ba` opens it and stores `addr` as its row. An activate to a bank that is already open reports code 1.
- R5: An activate is checked against three spacings. A gap under T_RC cycles since the same bank's last activate reports code 2. A gap under T_RRD cycles since any activate reports code 3. A gap under T_RP cycles since the same bank's last precharge reports code 4.
- R6: A read or write to an idle bank reports code 5. One issued fewer than T_RCD cycles after that bank's activate reports code 6.
- R7: A legal read or write with addr[8]=1 closes its bank at that edge and starts the bank's precharge spacing.
- R8: A precharge with addr[8]=0 targets bank `ba`; with addr[8]=1 it targets every open bank. If any targeted open bank was activated fewer than T_RAS cycles earlier, it reports code 10 and closes nothing.
- R9: A precharge to a bank with no open row is accepted with code 0 and changes no bank state.
- R10: Auto refresh or mode load while any bank is open reports code 7. Auto refresh within T_RP cycles of any precharge reports code 4. A mode load with `ba` above 1 reports code 11.
- R11: Any command other than deselect or no-op reports code 8 if it comes within T_RFC cycles of an accepted refresh. It reports code 9 if it comes within T_MRD cycles of an accepted mode load. These two checks take priority over all others, code 8 first.
- R12: A flagged command changes no bank state and restarts no spacing counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (12) | Address; row on activate, bit 8 selects all-bank or auto-precharge |
| cmd_code | output | 4 | Decoded command of the previous edge |
| viol | output | 1 | Violation flag of the previous edge |
| viol_code | output | 4 | Violation reason, 0 when legal |
| bank_open | output | BANKS (4) | One bit per bank, 1 when a row is open |
| open_row | output | BANKS*ADDR_W (48) | Open row of each bank, bank 0 in the low bits |

## Verification
A bank tracked in the wrong state shows up in `bank_open` one cycle after the command that should have moved it. It then shows up again as a false or missing code 1, 5 or 7 on the next command aimed at that bank. A spacing counter that is off by one is only visible on a command issued exactly at the limit. The bench therefore places commands one cycle short of each spacing and then at the spacing itself. A wrong priority order shows up as a swapped reason code in the same cycle the command is reported.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_BST   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_LMR   = 4'd8
    } sd_cmd_e;

    typedef enum logic [3:0] {
        V_NONE     = 4'd0,
        V_ACT_OPEN = 4'd1,
        V_RC       = 4'd2,
        V_RRD      = 4'd3,
        V_RP       = 4'd4,
        V_CLOSED   = 4'd5,
        V_RCD      = 4'd6,
        V_BUSY     = 4'd7,
        V_RFC      = 4'd8,
        V_MRD      = 4'd9,
        V_RAS      = 4'd10,
        V_MODE_SEL = 4'd11
    } sd_viol_e;

    typedef struct packed {
        sd_cmd_e  cmd;
        sd_viol_e viol;
    } sd_result_t;

    function automatic sd_cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        sd_cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b110:  c = CMD_BST;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b011:  c = CMD_ACT;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                default: c = CMD_LMR;
            endcase
        end
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdct_decode.sv
module sdct_decode
    import sdct_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    output sd_cmd_e cmd
);
    always_comb cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdct_timer.sv
module sdct_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= SAT;
        end else if (restart) begin
            count <= CW'(1);
        end else if (count != SAT) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/sdct_bank.sv
module sdct_bank #(
    parameter int ROW_W = 12,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row,
    output logic [CW-1:0]    since_act,
    output logic [CW-1:0]    since_pre
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row     <= '0;
        end else if (open_req) begin
            is_open <= 1'b1;
            row     <= row_in;
        end else if (close_req) begin
            is_open <= 1'b0;
        end
    end

    sdct_timer #(.CW(CW)) u_act_t (
        .clk(clk), .rst(rst), .restart(open_req), .count(since_act)
    );

    sdct_timer #(.CW(CW)) u_pre_t (
        .clk(clk), .rst(rst), .restart(close_req), .count(since_pre)
    );
endmodule

// File: rtl/sdct_rules.sv
module sdct_rules
    import sdct_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = 2,
    parameter int CW    = 4,
    parameter int T_RCD = 4,
    parameter int T_RP  = 3,
    parameter int T_RRD = 2,
    parameter int T_RC  = 12,
    parameter int T_RFC = 14,
    parameter int T_MRD = 2,
    parameter int T_RAS = 8
) (
    input  sd_cmd_e                cmd,
    input  logic [BA_W-1:0]        ba,
    input  logic                   ap_bit,
    input  logic [NB-1:0]          bank_open,
    input  logic [NB-1:0][CW-1:0]  since_act,
    input  logic [NB-1:0][CW-1:0]  since_pre,
    input  logic [CW-1:0]          since_any_act,
    input  logic [CW-1:0]          since_ref,
    input  logic [CW-1:0]          since_lmr,
    output sd_viol_e               verdict,
    output logic [NB-1:0]          open_mask,
    output logic [NB-1:0]          close_mask,
    output logic                   ref_go,
    output logic                   lmr_go
);
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP);
    localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC);
    localparam logic [CW-1:0] L_RFC = CW'(T_RFC);
    localparam logic [CW-1:0] L_MRD = CW'(T_MRD);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
    localparam logic [BA_W-1:0] LAST_MODE_SEL = BA_W'(1);

    logic          any_open;
    logic          any_pre_young;
    logic [NB-1:0] ras_young;
    logic [NB-1:0] pre_targets;
    logic          busy_cmd;

    always_comb begin
        any_open      = |bank_open;
        any_pre_young = 1'b0;
        for (int b = 0; b < NB; b++) begin
            ras_young[b] = bank_open[b] && (since_act[b] < L_RAS);
            if (since_pre[b] < L_RP) any_pre_young = 1'b1;
        end
        pre_targets = '0;
        if (ap_bit) pre_targets = bank_open;
        else        pre_targets[ba] = bank_open[ba];
        busy_cmd = (cmd != CMD_DESEL) && (cmd != CMD_NOP);
    end

    always_comb begin
        verdict    = V_NONE;
        open_mask  = '0;
        close_mask = '0;
        ref_go     = 1'b0;
        lmr_go     = 1'b0;
        if (busy_cmd && (since_ref < L_RFC)) begin
            verdict = V_RFC;
        end else if (busy_cmd && (since_lmr < L_MRD)) begin
            verdict = V_MRD;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    if (bank_open[ba])                  verdict = V_ACT_OPEN;
                    else if (since_act[ba] < L_RC)      verdict = V_RC;
                    else if (since_any_act < L_RRD)     verdict = V_RRD;
                    else if (since_pre[ba] < L_RP)      verdict = V_RP;
                    else                                open_mask[ba] = 1'b1;
                end
                CMD_RD, CMD_WR: begin
                    if (!bank_open[ba])                 verdict = V_CLOSED;
                    else if (since_act[ba] < L_RCD)     verdict = V_RCD;
                    else if (ap_bit)                    close_mask[ba] = 1'b1;
                end
                CMD_PRE: begin
                    if (|(pre_targets & ras_young))     verdict = V_RAS;
                    else                                close_mask = pre_targets;
                end
                CMD_REF: begin
                    if (any_open)                       verdict = V_BUSY;
                    else if (any_pre_young)             verdict = V_RP;
                    else                                ref_go = 1'b1;
                end
                CMD_LMR: begin
                    if (ba > LAST_MODE_SEL)             verdict = V_MODE_SEL;
                    else if (any_open)                  verdict = V_BUSY;
                    else                                lmr_go = 1'b1;
                end
                default: verdict = V_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdct_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 8,
    parameter int T_RCD  = 4,
    parameter int T_RP   = 3,
    parameter int T_RRD  = 2,
    parameter int T_RC   = 12,
    parameter int T_RFC  = 14,
    parameter int T_MRD  = 2,
    parameter int T_RAS  = 8,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic [ADDR_W-1:0]         addr,
    output logic [3:0]                cmd_code,
    output logic                      viol,
    output logic [3:0]                viol_code,
    output logic [BANKS-1:0]          bank_open,
    output logic [BANKS*ADDR_W-1:0]   open_row
);
    localparam int T_MAX = max_of(max_of(max_of(T_RCD, T_RP), max_of(T_RRD, T_RC)),
                                  max_of(max_of(T_RFC, T_MRD), T_RAS));
    localparam int CW    = $clog2(T_MAX + 1);

    sd_cmd_e                   cmd;
    sd_viol_e                  verdict;
    sd_result_t                result_q;
    logic [BANKS-1:0]          open_mask;
    logic [BANKS-1:0]          close_mask;
    logic                      ref_go;
    logic                      lmr_go;
    logic [BANKS-1:0][CW-1:0]  since_act;
    logic [BANKS-1:0][CW-1:0]  since_pre;
    logic [CW-1:0]             since_any_act;
    logic [CW-1:0]             since_ref;
    logic [CW-1:0]             since_lmr;

    sdct_decode u_decode (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    sdct_rules #(
        .NB(BANKS), .BA_W(BA_W), .CW(CW),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
        .T_RFC(T_RFC), .T_MRD(T_MRD), .T_RAS(T_RAS)
    ) u_rules (
        .cmd(cmd), .ba(ba), .ap_bit(addr[AP_BIT]),
        .bank_open(bank_open), .since_act(since_act), .since_pre(since_pre),
        .since_any_act(since_any_act), .since_ref(since_ref), .since_lmr(since_lmr),
        .verdict(verdict), .open_mask(open_mask), .close_mask(close_mask),
        .ref_go(ref_go), .lmr_go(lmr_go)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sdct_bank #(.ROW_W(ADDR_W), .CW(CW)) u_bank (
            .clk(clk), .rst(rst),
            .open_req(open_mask[b]), .close_req(close_mask[b]),
            .row_in(addr),
            .is_open(bank_open[b]),
            .row(open_row[b*ADDR_W +: ADDR_W]),
            .since_act(since_act[b]),
            .since_pre(since_pre[b])
        );
    end

    sdct_timer #(.CW(CW)) u_rrd_t (
        .clk(clk), .rst(rst), .restart(|open_mask), .count(since_any_act)
    );
    sdct_timer #(.CW(CW)) u_rfc_t (
        .clk(clk), .rst(rst), .restart(ref_go), .count(since_ref)
    );
    sdct_timer #(.CW(CW)) u_mrd_t (
        .clk(clk), .rst(rst), .restart(lmr_go), .count(since_lmr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '{cmd: CMD_DESEL, viol: V_NONE};
        end else begin
            result_q <= '{cmd: cmd, viol: verdict};
        end
    end

    assign cmd_code  = result_q.cmd;
    assign viol_code = result_q.viol;
    assign viol      = (result_q.viol != V_NONE);
endmodule

// File: rtl/sdct_checker.sv
module sdct_checker #(
    parameter int BANKS  = 4,
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int T_RRD  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [BA_W-1:0]         ba,
    input logic [ADDR_W-1:0]       addr,
    input logic [3:0]              cmd_code,
    input logic                    viol,
    input logic [BANKS-1:0]        bank_open,
    input logic [BANKS*ADDR_W-1:0] open_row
);
    logic [BA_W-1:0]   ba_d;
    logic [ADDR_W-1:0] addr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ba_d   <= '0;
            addr_d <= '0;
        end else begin
            ba_d   <= ba;
            addr_d <= addr;
        end
    end

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd0 || cmd_code == 4'd1) |-> !viol);

    // R4
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd5 && !viol) |->
            (bank_open[ba_d] && open_row[ba_d*ADDR_W +: ADDR_W] == addr_d));

    // R12
    viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> (bank_open == $past(bank_open)));

    // R10
    ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd7 && !viol) |-> (bank_open == '0));

    // R5
    rrd_space_chk: assert property (@(posedge clk) disable iff (rst)
        (T_RRD > 1 && cmd_code == 4'd5 && !viol) |=> !(cmd_code == 4'd5 && !viol));

    // R9
    pre_never_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 4'd6) |-> ((bank_open & ~$past(bank_open)) == '0));
endmodule

bind sdcmd_tracker sdct_checker #(
    .BANKS(BANKS), .ADDR_W(ADDR_W), .BA_W(BA_W), .T_RRD(T_RRD)
) u_sdct_checker (
    .clk(clk), .rst(rst), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .viol(viol), .bank_open(bank_open), .open_row(open_row)
);

// File: tb/sdcmd_tracker_bench.sv
module sdcmd_tracker_bench;
    localparam logic [3:0] P_DESEL = 4'b1111;
    localparam logic [3:0] P_NOP   = 4'b0111;
    localparam logic [3:0] P_BST   = 4'b0110;
    localparam logic [3:0] P_RD    = 4'b0101;
    localparam logic [3:0] P_WR    = 4'b0100;
    localparam logic [3:0] P_ACT   = 4'b0011;
    localparam logic [3:0] P_PRE   = 4'b0010;
    localparam logic [3:0] P_REF   = 4'b0001;
    localparam logic [3:0] P_LMR   = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        viol;
    logic [3:0]  viol_code;
    logic [3:0]  bank_open;
    logic [47:0] open_row;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [3:0] cmd;
        logic [3:0] code;
        logic [3:0] open;
        string      tag;
    } exp_t;
    exp_t sb[$];

    sdcmd_tracker u_sdcmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cmd_code(cmd_code), .viol(viol), .viol_code(viol_code),
        .bank_open(bank_open), .open_row(open_row)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic [11:0] a,
                         input logic [3:0] ecmd, input logic [3:0] ecode,
                         input logic [3:0] eopen, input string tag);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba   = b;
        addr = a;
        e.cmd = ecmd; e.code = ecode; e.open = eopen; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic nops(input int n, input logic [3:0] eopen);
        for (int i = 0; i < n; i++) issue(P_NOP, 2'd0, 12'h000, 4'd1, 4'd0, eopen, "R1 nop");
    endtask

    task automatic row_check(input int b, input logic [11:0] exp, input string tag);
        @(posedge clk);
        #6;
        check(tag, open_row[b*12 +: 12], exp);
    endtask

    // monitor: pops one expectation per edge after a command was driven
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " cmd"},  cmd_code,  e.cmd);
                check({e.tag, " code"}, viol_code, e.code);
                check({e.tag, " viol"}, viol,      (e.code != 4'd0));
                check({e.tag, " open"}, bank_open, e.open);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        check("R3 reset cmd",  cmd_code,  4'd0);
        check("R3 reset viol", viol,      1'b0);
        check("R3 reset open", bank_open, 4'd0);
        check("R3 reset rows", open_row,  48'd0);

        issue(P_LMR, 2'd2, 12'h032, 4'd8, 4'd11, 4'b0000, "R10 mode sel");
        issue(P_LMR, 2'd0, 12'h032, 4'd8, 4'd0,  4'b0000, "R10 mode ok");
        issue(P_ACT, 2'd0, 12'h123, 4'd5, 4'd9,  4'b0000, "R11 mrd");
        issue(P_ACT, 2'd0, 12'h123, 4'd5, 4'd0,  4'b0001, "R4 act b0");
        row_check(0, 12'h123, "R4 row b0");
        issue(P_ACT, 2'd1, 12'h0AB, 4'd5, 4'd3,  4'b0001, "R5 rrd");
        issue(P_ACT, 2'd1, 12'h0AB, 4'd5, 4'd0,  4'b0011, "R5 act b1");
        issue(P_RD,  2'd0, 12'h004, 4'd3, 4'd6,  4'b0011, "R6 rcd");
        issue(P_RD,  2'd0, 12'h004, 4'd3, 4'd0,  4'b0011, "R6 rd ok");
        issue(P_ACT, 2'd0, 12'h055, 4'd5, 4'd1,  4'b0011, "R4 act open");
        issue(P_RD,  2'd2, 12'h000, 4'd3, 4'd5,  4'b0011, "R6 closed");
        issue(P_PRE, 2'd0, 12'h000, 4'd6, 4'd10, 4'b0011, "R8 ras");
        issue(P_PRE, 2'd0, 12'h000, 4'd6, 4'd0,  4'b0010, "R8 pre b0");
        issue(P_PRE, 2'd0, 12'h000, 4'd6, 4'd0,  4'b0010, "R9 pre idle");
        issue(P_ACT, 2'd0, 12'h200, 4'd5, 4'd2,  4'b0010, "R5 rc");
        nops(1, 4'b0010);
        issue(P_ACT, 2'd0, 12'h200, 4'd5, 4'd0,  4'b0011, "R5 rc met");
        issue(P_PRE, 2'd1, 12'h000, 4'd6, 4'd0,  4'b0001, "R8 pre b1");
        issue(P_ACT, 2'd1, 12'h0CD, 4'd5, 4'd4,  4'b0001, "R5 rp");
        nops(1, 4'b0001);
        issue(P_ACT, 2'd1, 12'h0CD, 4'd5, 4'd0,  4'b0011, "R5 rp met");
        issue(P_WR,  2'd1, 12'h100, 4'd4, 4'd6,  4'b0011, "R12 wr rcd no close");
        nops(2, 4'b0011);
        issue(P_WR,  2'd1, 12'h100, 4'd4, 4'd0,  4'b0001, "R7 auto pre");
        issue(P_REF, 2'd0, 12'h000, 4'd7, 4'd7,  4'b0001, "R10 ref busy");
        issue(P_PRE, 2'd2, 12'h100, 4'd6, 4'd0,  4'b0000, "R8 pre all");
        issue(P_REF, 2'd0, 12'h000, 4'd7, 4'd4,  4'b0000, "R10 ref rp");
        nops(1, 4'b0000);
        issue(P_REF, 2'd0, 12'h000, 4'd7, 4'd0,  4'b0000, "R10 ref ok");
        issue(P_ACT, 2'd2, 12'h777, 4'd5, 4'd8,  4'b0000, "R11 rfc");
        nops(12, 4'b0000);
        issue(P_ACT, 2'd3, 12'hFFF, 4'd5, 4'd0,  4'b1000, "R11 rfc met");
        row_check(3, 12'hFFF, "R4 row b3");
        issue(P_BST, 2'd0, 12'h000, 4'd2, 4'd0,  4'b1000, "R1 bst");
        issue(P_LMR, 2'd1, 12'h000, 4'd8, 4'd7,  4'b1000, "R10 lmr busy");
        issue(P_WR,  2'd3, 12'h000, 4'd4, 4'd6,  4'b1000, "R6 wr rcd");
        issue(P_DESEL, 2'd0, 12'h000, 4'd0, 4'd0, 4'b1000, "R2 desel clears");
        nops(2, 4'b1000);
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule